// File: doc/BRIEF.md
# Command Mailbox Register File

This block sits between a host bus and a disk controller engine. The host writes the address of a command block into four byte-wide address registers, chooses a width of addressing through an address-modifier register, and sets an add bit in the control/status register. The block then offers that address to the engine on a submit handshake. The engine reports each finished command block on a completion stream. The block queues those completions and returns them to the host one at a time, through the same address registers. An interrupt line is raised while a returned address waits for the host.

The control/status register gives some bits one meaning on read and another on write. Add is write-one-to-start and reads back as add pending. Clear-remove is write-one and reads back as remove pending. The busy bit is read-only, and whatever the host writes to it is dropped. A soft reset bit runs a timed sequence. The sequence empties the completion queue, drops both handshakes, clears the count of active blocks and clears the fatal-error register. The address registers, the modifier, maintenance mode and the semaphore keep their values.

Three state machines do the work. The submit machine has the states SUB_IDLE and SUB_PEND. It moves SUB_IDLE→SUB_PEND on an accepted add write and SUB_PEND→SUB_IDLE at the submit handshake. The remove machine has the states REM_IDLE and REM_SHOW. It moves REM_IDLE→REM_SHOW when it pops a queued completion and REM_SHOW→REM_IDLE on the clear write. The soft-reset sequencer has the states RST_RUN and RST_HOLD. It moves RST_RUN→RST_HOLD on a reset write and RST_HOLD→RST_RUN when its cycle counter runs out. A soft reset forces both of the other machines back to idle.

Top module: `cbm_mailbox`

## Requirements
- R1: Each register sits at an odd byte offset. Address bytes 0 (least significant) to 3 are at offsets 1, 3, 5 and 7, the modifier is at 9, control/status is at 11 and fatal error is at 13. Even offsets and offset 15 read 0 and ignore writes. The fatal-error register ignores host writes. Every register resets to 0.
- R2: Control/status reads as follows. Bit 7 is busy, which is the engine busy input OR a soft reset in progress. Bit 6 is 1 when the fatal-error register is nonzero. Bit 5 is maintenance mode. Bit 4 is 0. Bit 3 is soft reset in progress. Bit 2 is add pending. Bit 1 is remove pending. Bit 0 is the semaphore.
- R3: A control/status write stores bit 5 (maintenance mode, also driven on `maint_mode`) and bit 0 (semaphore). Bit 7 of the written value has no effect.
- R4: Writing 1 to control/status bit 2 while no add is pending sets add pending from the next cycle on. It captures the address and drives `sub_valid` with it. Add pending clears at the clock edge of the submit handshake.
- R5: An add write while an add is pending is ignored. `sub_addr` stays the same until the handshake, even if the address registers change.
- R6: When the modifier equals 0x0D the submitted address is the full 32 bits and `sub_wide`=1. Any other value (0x3D is the standard one) submits only the low 24 bits, with the upper byte zero, and `sub_wide`=0.
- R7: At most MAX_ACTIVE (31) blocks are active. A block counts from its submit handshake until the host clears its completion. While the limit is reached, a pending add is not offered. It is offered in the cycle after a clear.
- R8: A completion accepted at a clock edge, with none pending, loads its address into the address registers and sets remove pending and `irq` at the next edge.
- R9: Writing 1 to control/status bit 1 drops remove pending and `irq` at that edge. Queued completions are then presented one at a time in arrival order, each one cycle after the previous clear. The queue holds 31 entries, and `cpl_ready` is 0 while it is full.
- R10: A cycle with `fatal_valid`=1 loads `fatal_code` into the fatal-error register.
- R11: Writing 1 to control/status bit 3 holds `eng_reset` and status bit 3 high for RST_CYCLES cycles. The sequence empties the queue and clears add pending, remove pending, the active count and the fatal register. Add and clear writes are ignored during the sequence. The address, modifier, maintenance and semaphore registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW (4) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sub_valid | output | 1 | Command-block address offered to the engine |
| sub_ready | input | 1 | Engine accepts the offered address |
| sub_addr | output | AW (32) | Offered command-block address |
| sub_wide | output | 1 | Offered address uses 32-bit addressing |
| cpl_valid | input | 1 | Engine reports a finished block |
| cpl_ready | output | 1 | Completion queue can accept |
| cpl_addr | input | AW (32) | Address of the finished block |
| eng_busy | input | 1 | Engine busy indication |
| fatal_valid | input | 1 | Engine reports a fatal error code |
| fatal_code | input | 8 | Fatal error code |
| eng_reset | output | 1 | Soft reset in progress, to the engine |
| maint_mode | output | 1 | Maintenance mode bit |
| irq | output | 1 | Completion waiting for the host |

## Verification
A submit machine stuck in SUB_PEND shows at the next status read as add pending that never clears. It also shows as a missing handshake one cycle after the engine is ready. A wrong active count shows either as an add that is offered while 31 blocks are still active, or as one that is still held one cycle after a clear. A remove machine or queue pointer that has gone wrong shows as the wrong address, or an address out of order, in the address registers one cycle after each clear. The same fault can also show as `irq` staying high in the cycle after the clear. A faulty reset sequencer shows as a status bit 3 pulse that is not exactly RST_CYCLES cycles long, or as a remove pending or fatal code that survives it.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    // control/status bit positions
    localparam int unsigned CSR_BUSY  = 7;
    localparam int unsigned CSR_FERR  = 6;
    localparam int unsigned CSR_MAINT = 5;
    localparam int unsigned CSR_SRST  = 3;
    localparam int unsigned CSR_ADD   = 2;
    localparam int unsigned CSR_REM   = 1;
    localparam int unsigned CSR_SEM   = 0;

    localparam logic [7:0] AMOD_WIDE   = 8'h0D;
    localparam logic [7:0] AMOD_NARROW = 8'h3D;

    typedef enum logic {SUB_IDLE, SUB_PEND} sub_state_e;
    typedef enum logic {REM_IDLE, REM_SHOW} rem_state_e;
    typedef enum logic {RST_RUN,  RST_HOLD} rst_state_e;
endpackage

// File: rtl/cbm_fifo.sv
module cbm_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign dout    = mem[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R9: the queue never receives more than it can hold
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cbm_sub_fsm.sv
module cbm_sub_fsm
    import cbm_pkg::*;
#(
    parameter int AW         = 32,
    parameter int MAX_ACTIVE = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          add_req,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    amod_in,
    input  logic          release_i,
    input  logic          sub_ready,
    output logic          sub_valid,
    output logic [AW-1:0] sub_addr,
    output logic          sub_wide,
    output logic          pending
);
    localparam int CW = $clog2(MAX_ACTIVE + 1);
    localparam logic [AW-1:0] NARROW_MASK = AW'(24'hFF_FFFF);

    sub_state_e    st, st_nx;
    logic [CW-1:0] act_cnt;
    logic          can_issue, hs, dec;

    assign can_issue = (act_cnt < CW'(MAX_ACTIVE));
    assign hs        = sub_valid && sub_ready;
    assign dec       = release_i && (act_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SUB_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (srst) st_nx = SUB_IDLE;
        else begin
            unique case (st)
                SUB_IDLE: if (add_req) st_nx = SUB_PEND;
                SUB_PEND: if (hs)      st_nx = SUB_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            SUB_IDLE: begin pending = 1'b0; sub_valid = 1'b0;      end
            SUB_PEND: begin pending = 1'b1; sub_valid = can_issue; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_addr <= '0;
            sub_wide <= 1'b0;
        end else if (st == SUB_IDLE && add_req && !srst) begin
            sub_wide <= (amod_in == AMOD_WIDE);
            sub_addr <= (amod_in == AMOD_WIDE) ? addr_in : (addr_in & NARROW_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    act_cnt <= '0;
        else if (srst) act_cnt <= '0;
        else           act_cnt <= act_cnt + CW'(hs) - CW'(dec);
    end

    // R5: an offered address holds until it is taken
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr)));
    // R7: no handshake beyond the active limit
    p_cap_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> (act_cnt < CW'(MAX_ACTIVE)));
    // R4: a handshake ends the pending add
    p_hs_ends_pend_r4: assert property (@(posedge clk) disable iff (!rst_n || srst)
        hs |=> !pending);
endmodule

// File: rtl/cbm_rem_fsm.sv
module cbm_rem_fsm
    import cbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic q_empty,
    input  logic clear_req,
    output logic pop,
    output logic pending,
    output logic release_o
);
    rem_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= REM_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (srst) st_nx = REM_IDLE;
        else begin
            unique case (st)
                REM_IDLE: if (!q_empty)  st_nx = REM_SHOW;
                REM_SHOW: if (clear_req) st_nx = REM_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            REM_IDLE: begin
                pending   = 1'b0;
                pop       = !q_empty && !srst;
                release_o = 1'b0;
            end
            REM_SHOW: begin
                pending   = 1'b1;
                pop       = 1'b0;
                release_o = clear_req && !srst;
            end
        endcase
    end

    // R9: the clear write drops remove pending at once
    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && clear_req && !srst) |=> !pending);
    // R8: remove pending only rises after a pop
    p_show_after_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(pop));
endmodule

// File: rtl/cbm_mailbox.sv
module cbm_mailbox
    import cbm_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int MAX_ACTIVE = 31,
    parameter int RST_CYCLES = 4,
    localparam int AW        = 8 * ADDR_BYTES,
    localparam int BUS_AW    = $clog2(2 * ADDR_BYTES + 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic [AW-1:0]     sub_addr,
    output logic              sub_wide,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [AW-1:0]     cpl_addr,
    input  logic              eng_busy,
    input  logic              fatal_valid,
    input  logic [7:0]        fatal_code,
    output logic              eng_reset,
    output logic              maint_mode,
    output logic              irq
);
    localparam int OFS_AMOD = 2 * ADDR_BYTES + 1;
    localparam int OFS_CSR  = 2 * ADDR_BYTES + 3;
    localparam int OFS_FERR = 2 * ADDR_BYTES + 5;
    localparam int RCW      = $clog2(RST_CYCLES + 1);

    logic [7:0]     abyte [ADDR_BYTES];
    logic [AW-1:0]  addr_cat;
    logic [7:0]     amod_q, ferr_q;
    logic           maint_q, sem_q;
    logic           csr_wr, add_req, clear_req, srst_req, srst;
    logic           add_pend, rem_pend, q_pop, q_full, q_empty, release_w;
    logic [AW-1:0]  q_head;
    rst_state_e     rst_st, rst_nx;
    logic [RCW-1:0] rst_cnt;

    // ---------------- write decode ----------------
    assign csr_wr    = bus_wr && (bus_addr == BUS_AW'(OFS_CSR));
    assign srst_req  = csr_wr && bus_wdata[CSR_SRST] && (rst_st == RST_RUN);
    assign add_req   = csr_wr && bus_wdata[CSR_ADD] && !bus_wdata[CSR_SRST] && !srst;
    assign clear_req = csr_wr && bus_wdata[CSR_REM] && !bus_wdata[CSR_SRST] && !srst;

    // ---------------- soft reset sequencer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_st <= RST_RUN;
        else        rst_st <= rst_nx;
    end

    always_comb begin
        rst_nx = rst_st;
        unique case (rst_st)
            RST_RUN:  if (srst_req)         rst_nx = RST_HOLD;
            RST_HOLD: if (rst_cnt == '0)    rst_nx = RST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              rst_cnt <= '0;
        else if (srst_req)                       rst_cnt <= RCW'(RST_CYCLES - 1);
        else if (rst_st == RST_HOLD && rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
    end

    always_comb begin
        unique case (rst_st)
            RST_RUN:  srst = 1'b0;
            RST_HOLD: srst = 1'b1;
        endcase
    end
    assign eng_reset = srst;

    // ---------------- address registers ----------------
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_abyte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                abyte[k] <= '0;
            else if (q_pop)
                abyte[k] <= q_head[8*k +: 8];
            else if (bus_wr && bus_addr == BUS_AW'(2 * k + 1))
                abyte[k] <= bus_wdata;
        end
        assign addr_cat[8*k +: 8] = abyte[k];
    end

    // ---------------- modifier, control bits, fatal ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amod_q  <= '0;
            maint_q <= 1'b0;
            sem_q   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == BUS_AW'(OFS_AMOD)) amod_q <= bus_wdata;
            if (csr_wr) begin
                maint_q <= bus_wdata[CSR_MAINT];
                sem_q   <= bus_wdata[CSR_SEM];
            end
        end
    end
    assign maint_mode = maint_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ferr_q <= '0;
        else if (srst)        ferr_q <= '0;
        else if (fatal_valid) ferr_q <= fatal_code;
    end

    // ---------------- engine side ----------------
    cbm_sub_fsm #(.AW(AW), .MAX_ACTIVE(MAX_ACTIVE)) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .add_req   (add_req),
        .addr_in   (addr_cat),
        .amod_in   (amod_q),
        .release_i (release_w),
        .sub_ready (sub_ready),
        .sub_valid (sub_valid),
        .sub_addr  (sub_addr),
        .sub_wide  (sub_wide),
        .pending   (add_pend)
    );

    assign cpl_ready = !q_full && !srst;

    cbm_fifo #(.W(AW), .DEPTH(MAX_ACTIVE)) u_cplq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (srst),
        .push  (cpl_valid && cpl_ready),
        .din   (cpl_addr),
        .pop   (q_pop),
        .dout  (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    cbm_rem_fsm u_rem (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .q_empty   (q_empty),
        .clear_req (clear_req),
        .pop       (q_pop),
        .pending   (rem_pend),
        .release_o (release_w)
    );
    assign irq = rem_pend;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (bus_addr == BUS_AW'(2 * k + 1)) bus_rdata = abyte[k];
        if (bus_addr == BUS_AW'(OFS_AMOD)) bus_rdata = amod_q;
        if (bus_addr == BUS_AW'(OFS_FERR)) bus_rdata = ferr_q;
        if (bus_addr == BUS_AW'(OFS_CSR)) begin
            bus_rdata[CSR_BUSY]  = eng_busy || srst;
            bus_rdata[CSR_FERR]  = (ferr_q != '0);
            bus_rdata[CSR_MAINT] = maint_q;
            bus_rdata[CSR_SRST]  = srst;
            bus_rdata[CSR_ADD]   = add_pend;
            bus_rdata[CSR_REM]   = rem_pend;
            bus_rdata[CSR_SEM]   = sem_q;
        end
    end

    // R11: a soft reset leaves neither handshake pending
    p_srst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!add_pend && !rem_pend));
    // R10: a fatal report is visible in the register next cycle
    p_fatal_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_valid && !srst) |=> (ferr_q == $past(fatal_code)));
    // R8: the address registers take the head of the queue on a pop
    p_load_on_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (addr_cat == $past(q_head)));
endmodule

// File: tb/cbm_mailbox_tb.sv
`timescale 1ns/1ps
module cbm_mailbox_tb;
    localparam int RSTC = 4;
    localparam int MAXA = 31;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        sub_valid, sub_ready = 0, sub_wide;
    logic [31:0] sub_addr;
    logic        cpl_valid = 0, cpl_ready;
    logic [31:0] cpl_addr = '0;
    logic        eng_busy = 0, fatal_valid = 0;
    logic [7:0]  fatal_code = '0;
    logic        eng_reset, maint_mode, irq;

    int n_chk = 0, n_bad = 0;
    int hs_n = 0, cpl_n = 0;
    logic [31:0] hs_addr [64];
    logic        hs_wide [64];

    always #5 clk = ~clk;

    cbm_mailbox #(.MAX_ACTIVE(MAXA), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_valid(sub_valid),
        .sub_ready(sub_ready), .sub_addr(sub_addr), .sub_wide(sub_wide),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_addr(cpl_addr),
        .eng_busy(eng_busy), .fatal_valid(fatal_valid), .fatal_code(fatal_code),
        .eng_reset(eng_reset), .maint_mode(maint_mode), .irq(irq));

    // engine model: record handshakes and accepted completions
    always @(posedge clk) begin
        if (rst_n && sub_valid && sub_ready) begin
            hs_addr[hs_n % 64] <= sub_addr;
            hs_wide[hs_n % 64] <= sub_wide;
            hs_n <= hs_n + 1;
        end
        if (rst_n && cpl_valid && cpl_ready) cpl_n <= cpl_n + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_addr(output logic [31:0] v);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            rd(4'(2 * k + 1), b);
            v[8*k +: 8] = b;
        end
    endtask

    task automatic set_addr(input logic [31:0] v);
        for (int k = 0; k < 4; k++) wr(4'(2 * k + 1), v[8*k +: 8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [31:0] v;
        int          exp_hs, n;
        logic [7:0]  mods [5];
        mods[0] = 8'h3D; mods[1] = 8'h0D; mods[2] = 8'h00; mods[3] = 8'h2D; mods[4] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset values at every offset
        for (int o = 0; o < 16; o++) begin
            rd(4'(o), d);
            check($sformatf("R1 reset ofs %0d", o), 32'(d), 32'd0);
        end
        check("R8 irq low after reset", 32'(irq), 32'd0);

        // R1: sweep writes over every offset except control/status
        for (int o = 0; o < 16; o++)
            if (o != 11) wr(4'(o), 8'(8'h40 + o));
        for (int o = 0; o < 16; o++) begin
            rd(4'(o), d);
            if (o == 1 || o == 3 || o == 5 || o == 7 || o == 9)
                check($sformatf("R1 map ofs %0d", o), 32'(d), 32'(8'h40 + o));
            else
                check($sformatf("R1 map ofs %0d", o), 32'(d), 32'd0);
        end

        // R2/R3: sweep busy input and the stored/ignored bits
        for (int m = 0; m < 16; m++) begin
            eng_busy = m[3];
            wr(4'd11, {m[2], 1'b0, m[1], 4'b0000, m[0]});
            rd(4'd11, d);
            check($sformatf("R2 R3 csr m=%0d", m), 32'(d),
                  32'({m[3], 1'b0, m[1], 4'b0000, m[0]}));
            check($sformatf("R3 maint_mode m=%0d", m), 32'(maint_mode), 32'(m[1]));
        end
        eng_busy = 0;
        wr(4'd11, 8'h00);

        // R4/R6: add with 32-bit modifier, engine not ready
        set_addr(32'h1122_3344);
        wr(4'd9, 8'h0D);
        wr(4'd11, 8'h04);
        rd(4'd11, d);
        check("R4 add pending bit", 32'(d[2]), 32'd1);
        check("R4 sub_valid", 32'(sub_valid), 32'd1);
        check("R6 sub_addr wide", sub_addr, 32'h1122_3344);
        check("R6 sub_wide", 32'(sub_wide), 32'd1);
        // R5: second add and new address while pending
        wr(4'd1, 8'h99);
        wr(4'd11, 8'h04);
        check("R5 address held", sub_addr, 32'h1122_3344);
        @(negedge clk) sub_ready = 1;
        @(negedge clk) sub_ready = 0;
        rd(4'd11, d);
        check("R4 pending cleared", 32'(d[2]), 32'd0);
        check("R5 single handshake", 32'(hs_n), 32'd1);
        check("R4 handshake addr", hs_addr[0], 32'h1122_3344);
        exp_hs = 1;

        // R6: modifier sweep
        sub_ready = 1;
        for (int i = 0; i < 5; i++) begin
            wr(4'd9, mods[i]);
            wr(4'd11, 8'h04);
            @(negedge clk);
            exp_hs++;
            check($sformatf("R6 count mod %h", mods[i]), 32'(hs_n), 32'(exp_hs));
            check($sformatf("R6 addr mod %h", mods[i]), hs_addr[exp_hs - 1],
                  (mods[i] == 8'h0D) ? 32'h1122_3399 : 32'h0022_3399);
            check($sformatf("R6 wide mod %h", mods[i]), 32'(hs_wide[exp_hs - 1]),
                  32'(mods[i] == 8'h0D));
        end

        // R7: fill to the active limit
        while (exp_hs < MAXA) begin
            wr(4'd1, 8'(exp_hs));
            wr(4'd11, 8'h04);
            @(negedge clk);
            exp_hs++;
        end
        check("R7 count at limit", 32'(hs_n), 32'(MAXA));
        wr(4'd11, 8'h04);
        repeat (5) @(negedge clk);
        rd(4'd11, d);
        check("R7 add held at limit", 32'(d[2]), 32'd1);
        check("R7 no extra handshake", 32'(hs_n), 32'(MAXA));

        // R8: one completion
        @(negedge clk) begin cpl_valid = 1; cpl_addr = 32'hCAFE_0001; end
        @(negedge clk) cpl_valid = 0;
        rd(4'd11, d);
        check("R8 remove pending", 32'(d[1]), 32'd1);
        check("R8 irq", 32'(irq), 32'd1);
        rd_addr(v);
        check("R8 completed address", v, 32'hCAFE_0001);
        check("R7 still held before clear", 32'(hs_n), 32'(MAXA));
        wr(4'd11, 8'h02);
        check("R9 irq drops on clear", 32'(irq), 32'd0);
        @(negedge clk);
        check("R7 released after clear", 32'(hs_n), 32'(MAXA + 1));
        sub_ready = 0;

        // R9: ordering of queued completions
        @(negedge clk) begin cpl_valid = 1; cpl_addr = 32'hA000_000A; end
        @(negedge clk) cpl_addr = 32'hB000_000B;
        @(negedge clk) cpl_addr = 32'hC000_000C;
        @(negedge clk) cpl_valid = 0;
        rd_addr(v);
        check("R9 first in order", v, 32'hA000_000A);
        wr(4'd11, 8'h02);
        check("R9 irq low after clear A", 32'(irq), 32'd0);
        rd_addr(v);
        check("R9 second in order", v, 32'hB000_000B);
        check("R9 irq for second", 32'(irq), 32'd1);
        wr(4'd11, 8'h02);
        rd_addr(v);
        check("R9 third in order", v, 32'hC000_000C);
        wr(4'd11, 8'h02);
        repeat (2) @(negedge clk);
        rd(4'd11, d);
        check("R9 queue drained", 32'(d[1]), 32'd0);

        // R9: fill the queue
        n = cpl_n;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk) begin cpl_valid = 1; cpl_addr = 32'h5000_0000 + 32'(i); end
        end
        @(negedge clk) cpl_valid = 0;
        check("R9 all accepted", 32'(cpl_n - n), 32'd32);
        check("R9 ready low when full", 32'(cpl_ready), 32'd0);

        // R10: fatal register
        @(negedge clk) begin fatal_valid = 1; fatal_code = 8'h43; end
        @(negedge clk) fatal_valid = 0;
        rd(4'd13, d);
        check("R10 fatal code", 32'(d), 32'h43);
        wr(4'd13, 8'h00);
        rd(4'd11, d);
        check("R10 fatal flag (host write ignored)", 32'(d[6]), 32'd1);

        // R11: soft reset with maintenance set
        wr(4'd11, 8'h28);
        bus_addr = 4'd11;
        #1;
        check("R2 busy during reset", 32'(bus_rdata[7]), 32'd1);
        check("R11 eng_reset", 32'(eng_reset), 32'd1);
        n = 0;
        while (bus_rdata[3] && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
        check("R11 reset length", 32'(n), 32'(RSTC));
        rd(4'd11, d);
        check("R11 csr after reset", 32'(d), 32'h20);
        check("R11 irq after reset", 32'(irq), 32'd0);
        check("R11 cpl_ready after reset", 32'(cpl_ready), 32'd1);
        rd(4'd13, d);
        check("R11 fatal cleared", 32'(d), 32'd0);
        rd_addr(v);
        check("R11 address kept", v, 32'h5000_0000);
        rd(4'd9, d);
        check("R11 modifier kept", 32'(d), 32'hFF);
        repeat (3) @(negedge clk);
        rd(4'd11, d);
        check("R11 queue emptied", 32'(d[1]), 32'd0);
        n = hs_n;
        sub_ready = 1;
        wr(4'd11, 8'h04);
        @(negedge clk);
        check("R11 count cleared, add accepted", 32'(hs_n - n), 32'd1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule